// File: doc/BRIEF.md
# Audio Decoder Reset Sequencer

This block is a host-side controller that walks an external compressed-audio decoder through two fixed procedures. The first is power-up setup: it drives the active-low hardware reset line, releases it, and then programs the decoder's configuration registers. The second is the soft reset that must happen between tracks. That procedure can flush the decoder with zero bytes, sets the reset bit in the mode register, waits a minimum guard time, waits for the decoder's data-request line to come back, and then sends one trailing zero byte.

Register writes go out as an address/data request with a valid/ready handshake to a separate serial control-port engine. Data bytes go out as a valid/ready request to a data-port streamer. The host starts a procedure with a single-cycle start input. It watches `busy`, `done` (a one-cycle pulse) and a sticky `error` flag that is raised when the decoder never re-asserts data-request.

Top module: `adec_rst_seq`

## Requirements
- R1: After synchronous reset, `hw_rst_n` is 1, and `busy`, `done`, `error`, `reg_valid` and `byte_valid` are 0.
- R2: A `start_init` accepted in idle drives `hw_rst_n` low for at least `HWRST_CYC` cycles. No register write is offered while `hw_rst_n` is low.
- R3: After the reset line is released, init writes the clock register (address 0x3, data `CLKF_VAL`) only when `DEC_CLK_NOMINAL` is 0. It then writes the volume register (address 0xB, data `VOL_VAL`) and pulses `done`. No mode write and no data byte occur during init.
- R4: While `reg_valid` is high and `reg_ready` is low, `reg_valid`, `reg_addr` and `reg_data` hold steady. Each write transfers exactly once.
- R5: A track change started with `flush_en`=1 sends exactly `FLUSH_BYTES` bytes of value 0x00 before the mode write. `byte_valid` is only ever high while `dreq` is high. With `flush_en`=0, no byte precedes the mode write.
- R6: The soft-reset write goes to address 0x0 with data equal to `MODE_BASE` with bit 2 forced to 1 and every other bit kept as in `MODE_BASE`.
- R7: No data byte is offered earlier than GUARD_CYC = ceil(`MIN_WAIT_NS` x `HOST_CLK_KHZ` / 10^6) cycles after the mode write transfers.
- R8: After the guard time, `dreq` may stay low for up to ceil(`TIMEOUT_NS` x `HOST_CLK_KHZ` / 10^6) cycles without error. Once it is high, exactly one 0x00 byte is sent and then `done` pulses.
- R9: If `dreq` stays low past that timeout, `error` rises and stays high, `busy` drops, no trailing byte is sent and `done` does not pulse. The next accepted start clears `error`.
- R10: Start inputs are ignored while `busy` is high. If both starts arrive together in idle, init wins.
- R11: `done` is high for exactly one cycle, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| start_init | input | 1 | Start the power-up procedure |
| start_track_change | input | 1 | Start the between-track soft reset |
| flush_en | input | 1 | Send zero-byte flush before the soft reset (sampled at start) |
| dreq | input | 1 | Decoder data-request line |
| reg_ready | input | 1 | Control-port engine accepts the write |
| reg_valid | output | 1 | Register write request |
| reg_addr | output | 4 | Register address |
| reg_data | output | 16 | Register data |
| byte_ready | input | 1 | Data-port streamer accepts the byte |
| byte_valid | output | 1 | Data byte request |
| byte_data | output | 8 | Data byte (always 0x00) |
| hw_rst_n | output | 1 | Registered active-low decoder hardware reset |
| busy | output | 1 | A procedure is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky data-request timeout flag |

## Verification
Track changes run with `dreq` and both ready inputs toggling at random. This separates a flush that counts handshakes from one that counts cycles, and shows whether bytes leak out while `dreq` is low. Directed runs hold `dreq` low for a long time, once just inside the timeout and once forever. These runs separate correct waiting from a premature error, and a correct timeout from a hang. Further cases overlap starts with a running procedure and issue both starts in the same cycle, which exposes broken ignore and priority rules. Two instances that differ only in the clock-nominal setting show whether the clock-register write is conditional.

// File: rtl/adec_seq_pkg.sv
package adec_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_HWHOLD, S_WCLKF, S_WVOL, S_FLUSH, S_WMODE,
        S_GUARD, S_WAITRQ, S_TAIL, S_DONE, S_FAIL
    } seq_state_e;

    typedef struct packed {
        logic [3:0]  addr;
        logic [15:0] data;
    } reg_wr_t;

    localparam logic [3:0] ADDR_MODE = 4'h0;
    localparam logic [3:0] ADDR_CLKF = 4'h3;
    localparam logic [3:0] ADDR_VOL  = 4'hB;
    localparam int SOFT_RST_BIT = 2;

    // cycles covering a duration in ns at a clock in kHz, rounded up
    function automatic int cyc_for_ns(input longint ns, input longint khz);
        return int'((ns * khz + 64'd999999) / 64'd1000000);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adec_wait_ctr.sv
module adec_wait_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (en && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R7: the guard and timeout counters saturate and never wrap
    p_ctr_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (en && !load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/adec_zero_pacer.sv
module adec_zero_pacer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         fire,
    output logic         last
);
    logic [W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst)                       remaining <= '0;
        else if (load)                 remaining <= load_val;
        else if (fire && remaining != '0) remaining <= remaining - 1'b1;
    end

    assign last = (remaining == W'(1));

    // R5: a flush byte is never sent once the byte budget is used up
    p_flush_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        fire |-> (remaining != '0));
endmodule

// File: rtl/adec_rst_seq.sv
module adec_rst_seq
    import adec_seq_pkg::*;
#(
    parameter int          HOST_CLK_KHZ    = 200000,
    parameter int          MIN_WAIT_NS     = 2000,
    parameter int          TIMEOUT_NS      = 1000000,
    parameter int          HWRST_CYC       = 20,
    parameter int          FLUSH_BYTES     = 2048,
    parameter bit          DEC_CLK_NOMINAL = 1'b0,
    parameter logic [15:0] CLKF_VAL        = 16'h9800,
    parameter logic [15:0] VOL_VAL         = 16'h2020,
    parameter logic [15:0] MODE_BASE       = 16'h0800
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_init,
    input  logic        start_track_change,
    input  logic        flush_en,
    input  logic        dreq,
    input  logic        reg_ready,
    output logic        reg_valid,
    output logic [3:0]  reg_addr,
    output logic [15:0] reg_data,
    input  logic        byte_ready,
    output logic        byte_valid,
    output logic [7:0]  byte_data,
    output logic        hw_rst_n,
    output logic        busy,
    output logic        done,
    output logic        error
);
    localparam int GUARD_CYC = cyc_for_ns(MIN_WAIT_NS, HOST_CLK_KHZ);
    localparam int TO_CYC    = cyc_for_ns(TIMEOUT_NS, HOST_CLK_KHZ);
    localparam int TW        = $clog2(imax(HWRST_CYC, GUARD_CYC) + 1);
    localparam int TOW       = $clog2(TO_CYC + 1);
    localparam int FW        = $clog2(FLUSH_BYTES + 1);
    localparam logic [15:0] MODE_KEEP = MODE_BASE & ~(16'd1 << SOFT_RST_BIT);
    localparam logic [15:0] MODE_RST  = MODE_KEEP | (16'd1 << SOFT_RST_BIT);

    seq_state_e state_q, state_d;
    logic          accept, reg_fire, byte_fire;
    logic          tmr_load, tmr_zero, to_load, to_zero, pc_load, pc_last;
    logic [TW-1:0] tmr_val;
    logic          hw_rst_n_q, error_q;
    reg_wr_t       wr;

    assign accept    = (state_q == S_IDLE) && (start_init || start_track_change);
    assign reg_fire  = reg_valid && reg_ready;
    assign byte_fire = byte_valid && byte_ready;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        to_load  = 1'b0;
        pc_load  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_init) begin
                    state_d  = S_HWHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HWRST_CYC);
                end else if (start_track_change) begin
                    state_d = flush_en ? S_FLUSH : S_WMODE;
                    pc_load = flush_en;
                end
            end
            S_HWHOLD: if (tmr_zero) state_d = DEC_CLK_NOMINAL ? S_WVOL : S_WCLKF;
            S_WCLKF:  if (reg_fire) state_d = S_WVOL;
            S_WVOL:   if (reg_fire) state_d = S_DONE;
            S_FLUSH:  if (byte_fire && pc_last) state_d = S_WMODE;
            S_WMODE: begin
                if (reg_fire) begin
                    state_d  = S_GUARD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GUARD_CYC);
                end
            end
            S_GUARD: begin
                if (tmr_zero) begin
                    state_d = S_WAITRQ;
                    to_load = 1'b1;
                end
            end
            S_WAITRQ: begin
                if (dreq)         state_d = S_TAIL;
                else if (to_zero) state_d = S_FAIL;
            end
            S_TAIL:  if (byte_fire) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            S_FAIL:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            hw_rst_n_q <= 1'b1;
            error_q    <= 1'b0;
        end else begin
            state_q    <= state_d;
            hw_rst_n_q <= (state_d != S_HWHOLD);
            if (accept)                  error_q <= 1'b0;
            else if (state_q == S_FAIL)  error_q <= 1'b1;
        end
    end

    adec_wait_ctr #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .en(state_q == S_HWHOLD || state_q == S_GUARD), .zero(tmr_zero)
    );

    adec_wait_ctr #(.W(TOW)) u_timeout (
        .clk(clk), .rst(rst), .load(to_load), .load_val(TOW'(TO_CYC)),
        .en(state_q == S_WAITRQ), .zero(to_zero)
    );

    adec_zero_pacer #(.W(FW)) u_pacer (
        .clk(clk), .rst(rst), .load(pc_load), .load_val(FW'(FLUSH_BYTES)),
        .fire(byte_fire && state_q == S_FLUSH), .last(pc_last)
    );

    always_comb begin
        unique case (state_q)
            S_WCLKF: wr = '{addr: ADDR_CLKF, data: CLKF_VAL};
            S_WVOL:  wr = '{addr: ADDR_VOL,  data: VOL_VAL};
            S_WMODE: wr = '{addr: ADDR_MODE, data: MODE_RST};
            default: wr = '{addr: 4'h0,      data: 16'h0000};
        endcase
    end

    assign reg_valid  = (state_q == S_WCLKF) || (state_q == S_WVOL) || (state_q == S_WMODE);
    assign reg_addr   = wr.addr;
    assign reg_data   = wr.data;
    assign byte_valid = dreq && (state_q == S_FLUSH || state_q == S_TAIL);
    assign byte_data  = 8'h00;
    assign hw_rst_n   = hw_rst_n_q;
    assign busy       = (state_q != S_IDLE);
    assign done       = (state_q == S_DONE);
    assign error      = error_q;

    p_no_write_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
        !hw_rst_n |-> !reg_valid);

    p_reg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) && $stable(reg_data)));

    p_mode_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_addr == ADDR_MODE) |->
            (reg_data[SOFT_RST_BIT] && ((reg_data & ~(16'd1 << SOFT_RST_BIT)) == MODE_KEEP)));

    p_error_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (error && !start_init && !start_track_change) |=> error);

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start_init && hw_rst_n && state_q != S_HWHOLD) |=> hw_rst_n);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

// File: tb/sim_adec_rst_seq.sv
`timescale 1ns/1ps
module sim_adec_rst_seq;
    localparam int          HOST_KHZ = 200000;
    localparam int          MINW_NS  = 2000;
    localparam int          TO_NS    = 300000;
    localparam int          HWC      = 20;
    localparam int          NFLUSH   = 2048;
    localparam logic [15:0] CLKF     = 16'h9800;
    localparam logic [15:0] VOL      = 16'h2020;
    localparam logic [15:0] MBASE    = 16'h0824;

    logic clk = 1'b0, rst = 1'b1;
    logic start_init = 0, start_tc = 0, flush_en = 0, dreq = 0;
    logic reg_ready = 0, byte_ready = 0;
    logic reg_valid, byte_valid, hw_rst_n, busy, done, error;
    logic [3:0] reg_addr; logic [15:0] reg_data; logic [7:0] byte_data;
    logic u1_reg_valid, u1_byte_valid, u1_hw, u1_busy, u1_done, u1_err;
    logic [3:0] u1_addr; logic [15:0] u1_data; logic [7:0] u1_bdata;

    always #2.5 clk = ~clk;

    adec_rst_seq #(.HOST_CLK_KHZ(HOST_KHZ), .MIN_WAIT_NS(MINW_NS), .TIMEOUT_NS(TO_NS),
        .HWRST_CYC(HWC), .FLUSH_BYTES(NFLUSH), .DEC_CLK_NOMINAL(1'b0),
        .CLKF_VAL(CLKF), .VOL_VAL(VOL), .MODE_BASE(MBASE)) u0 (
        .clk(clk), .rst(rst), .start_init(start_init), .start_track_change(start_tc),
        .flush_en(flush_en), .dreq(dreq), .reg_ready(reg_ready), .reg_valid(reg_valid),
        .reg_addr(reg_addr), .reg_data(reg_data), .byte_ready(byte_ready),
        .byte_valid(byte_valid), .byte_data(byte_data), .hw_rst_n(hw_rst_n),
        .busy(busy), .done(done), .error(error));

    adec_rst_seq #(.HOST_CLK_KHZ(HOST_KHZ), .MIN_WAIT_NS(MINW_NS), .TIMEOUT_NS(TO_NS),
        .HWRST_CYC(HWC), .FLUSH_BYTES(NFLUSH), .DEC_CLK_NOMINAL(1'b1),
        .CLKF_VAL(CLKF), .VOL_VAL(VOL), .MODE_BASE(MBASE)) u1 (
        .clk(clk), .rst(rst), .start_init(start_init), .start_track_change(1'b0),
        .flush_en(1'b0), .dreq(1'b1), .reg_ready(1'b1), .reg_valid(u1_reg_valid),
        .reg_addr(u1_addr), .reg_data(u1_data), .byte_ready(1'b1),
        .byte_valid(u1_byte_valid), .byte_data(u1_bdata), .hw_rst_n(u1_hw),
        .busy(u1_busy), .done(u1_done), .error(u1_err));

    function automatic int exp_cycles(input longint ns);
        return int'((ns * HOST_KHZ + 999999) / 1000000);
    endfunction

    int n_vec = 0, n_bad = 0, cyc = 0, dreq_mode = 0;
    int wr_n, flush_n, tail_n, done_n, hw_low, mode_cyc, tail_cyc;
    int bad_byte, bad_rst_wr, bad_done, bad_hold, u1_first;
    logic [3:0] wr_a [16]; logic [15:0] wr_d [16];
    logic prev_done, prev_stall; logic [19:0] prev_req;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        wr_n = 0; flush_n = 0; tail_n = 0; done_n = 0; hw_low = 0;
        mode_cyc = -1; tail_cyc = -1; bad_byte = 0; bad_rst_wr = 0;
        bad_done = 0; bad_hold = 0; u1_first = -1;
    endtask

    // random handshake and data-request stimulus, driven after the edge
    always @(posedge clk) begin
        #1;
        reg_ready  <= ($urandom % 4) != 0;
        byte_ready <= ($urandom % 4) != 0;
        if (dreq_mode == 0) dreq <= ($urandom % 4) != 0;
        else                dreq <= (dreq_mode == 1);
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_stall && !(reg_valid && {reg_addr, reg_data} == prev_req)) bad_hold++;
            prev_stall = reg_valid && !reg_ready;
            prev_req   = {reg_addr, reg_data};
            if (reg_valid && reg_ready) begin
                if (wr_n < 16) begin wr_a[wr_n] = reg_addr; wr_d[wr_n] = reg_data; end
                wr_n++;
                if (reg_addr == 4'h0) mode_cyc = cyc;
            end
            if (byte_valid && (!dreq || byte_data != 8'h00)) bad_byte++;
            if (byte_valid && byte_ready) begin
                if (mode_cyc >= 0) begin
                    if (tail_n == 0) tail_cyc = cyc;
                    tail_n++;
                end else flush_n++;
            end
            if (!hw_rst_n) hw_low++;
            if (!hw_rst_n && reg_valid) bad_rst_wr++;
            if (done) begin done_n++; if (prev_done) bad_done++; end
            prev_done = done;
            if (u1_reg_valid && u1_first < 0) u1_first = int'(u1_addr);
        end
    end

    task automatic pulse(input bit si, input bit st);
        @(posedge clk); #1; start_init = si; start_tc = st;
        @(posedge clk); #1; start_init = 0; start_tc = 0;
    endtask

    task automatic wait_end();
        while (done_n == 0 && !(error && !busy)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic check_track(input bit fl, input string tag);
        chk(done_n == 1 && bad_done == 0, "R11 done single pulse", done_n, 1);
        chk(!busy && !error, {tag, " R8 idle without error"}, error, 0);
        chk(flush_n == (fl ? NFLUSH : 0), "R5 flush byte count", flush_n, fl ? NFLUSH : 0);
        chk(bad_byte == 0, "R5 byte only with dreq, value zero", bad_byte, 0);
        chk(wr_n == 1 && wr_a[0] == 4'h0, "R6 single mode write addr", wr_a[0], 0);
        chk(wr_d[0] == (MBASE | 16'h0004), "R6 mode data", wr_d[0], MBASE | 16'h0004);
        chk(tail_n == 1, "R8 one trailing byte", tail_n, 1);
        chk(tail_cyc - mode_cyc >= exp_cycles(MINW_NS), "R7 guard time",
            tail_cyc - mode_cyc, exp_cycles(MINW_NS));
        chk(bad_hold == 0, "R4 request held while stalled", bad_hold, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        report();
    end

    initial begin
        void'($urandom(32'h5eed1234));
        prev_done = 0; prev_stall = 0; prev_req = '0;
        clear_mon();
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(hw_rst_n && !busy && !done && !error && !reg_valid && !byte_valid,
            "R1 reset state", {hw_rst_n, busy, done, error, reg_valid, byte_valid}, 6'b100000);

        // init sequence
        clear_mon();
        pulse(1, 0);
        wait_end();
        chk(hw_low >= HWC, "R2 reset low length", hw_low, HWC);
        chk(bad_rst_wr == 0, "R2 no write while reset low", bad_rst_wr, 0);
        chk(wr_n == 2 && wr_a[0] == 4'h3 && wr_d[0] == CLKF, "R3 clock write first", wr_a[0], 3);
        chk(wr_a[1] == 4'hB && wr_d[1] == VOL, "R3 volume write", wr_d[1], VOL);
        chk(flush_n == 0 && tail_n == 0, "R3 no bytes in init", flush_n + tail_n, 0);
        chk(u1_first == 11, "R3 nominal clock skips clock write", u1_first, 11);
        chk(done_n == 1 && bad_done == 0, "R11 init done pulse", done_n, 1);
        chk(bad_hold == 0, "R4 init request held", bad_hold, 0);

        // random track changes, flush on and off
        for (int i = 0; i < 4; i++) begin
            bit fl;
            fl = (i % 2 == 0) ? 1'b1 : 1'b0;
            dreq_mode = 0; flush_en = fl; clear_mon();
            pulse(0, 1);
            flush_en = 0;
            wait_end();
            check_track(fl, "random");
        end

        // long dreq low, inside the timeout
        dreq_mode = 2; clear_mon();
        pulse(0, 1);
        repeat (51000) @(posedge clk);
        dreq_mode = 1;
        wait_end();
        check_track(0, "long low");

        // start ignored while busy
        dreq_mode = 1; clear_mon();
        pulse(0, 1);
        repeat (50) @(posedge clk);
        pulse(1, 0);
        wait_end();
        chk(hw_low == 0, "R10 init ignored while busy", hw_low, 0);
        chk(wr_n == 1 && done_n == 1, "R10 only the running sequence", wr_n, 1);

        // timeout
        dreq_mode = 2; clear_mon();
        pulse(0, 1);
        wait_end();
        repeat (3) @(negedge clk);
        chk(error && !busy, "R9 error raised, busy dropped", {error, busy}, 2'b10);
        chk(done_n == 0 && tail_n == 0, "R9 no done, no byte", done_n + tail_n, 0);
        chk(mode_cyc >= 0, "R9 mode write happened", mode_cyc >= 0, 1);

        // new start clears the flag
        dreq_mode = 1; clear_mon();
        pulse(0, 1);
        #1;
        chk(!error, "R9 start clears error", error, 0);
        wait_end();
        check_track(0, "after error");

        // both starts together: init wins
        clear_mon();
        pulse(1, 1);
        wait_end();
        chk(hw_low >= HWC, "R10 init has priority", hw_low, HWC);
        chk(wr_n == 2 && wr_a[1] == 4'hB, "R10 no mode write", wr_n, 2);

        report();
    end
endmodule